// File: doc/BRIEF.md
# Flash Program/Erase Control Register

This block is an 8-bit control and status register that steps a flash controller through program and erase operations on the upper bank of on-chip flash. Software writes one mode bit at a time, such as program setup, erase setup, a verify mode or an operate mode. The register passes those bits straight to the flash controller, which does the actual work.

Writes are qualified in several ways. Mode bits can only be held while an external flash-write-enable pin and a software-write-enable input are both high. A write that would leave two or more mode bits set is thrown away. An error reported while a program or erase operation is running sets a sticky, read-only error flag. That flag puts the bank into a protection state: every mode bit is cleared and stays cleared until reset.

A separate address comparator marks flash addresses that fall inside the bank this register governs.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After synchronous reset, `mode_o` is 0, `protect_o` is 0 and a read returns 0x00.
- R2: A read pulse on `reg_rd` returns the status byte on `reg_rdata` one cycle later. The byte is laid out as bit 7 error flag, bit 6 constant 0, bit 5 erase setup, bit 4 program setup, bit 3 erase verify, bit 2 program verify, bit 1 erase, bit 0 program. `mode_o` uses the same order for bits 5..0.
- R3: With both enables high and no error, a write whose bits 5..0 contain at most one 1 loads those bits into the mode register at the next clock.
- R4: A write whose bits 5..0 contain more than one 1 is discarded, and the previous mode bits are kept. `mode_o` never has more than one bit set.
- R5: Write data bits 7 and 6 are ignored. Writing 1 to bit 7 does not set the error flag, and bit 6 always reads 0.
- R6: While `fwe_pin` or `swe_en` is 0, writes cannot set any mode bit. When either enable is 0, all mode bits are 0 from the next clock on.
- R7: An `err_in` pulse while the erase bit (1) or the program bit (0) is set latches the error flag at the next clock. At that same clock all mode bits clear and `protect_o` rises.
- R8: An `err_in` pulse while neither the erase bit nor the program bit is set has no effect.
- R9: While the error flag is 1, mode bits stay 0 and writes are ignored. Only reset clears the flag.
- R10: `bank_hit` is combinationally 1 exactly when `flash_addr` lies in 0x20000..0x3FFFF inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after `reg_rd` |
| fwe_pin | input | 1 | Flash write enable pin |
| swe_en | input | 1 | Software write enable |
| err_in | input | 1 | Error report from the flash controller |
| flash_addr | input | FADDR_W (20) | Flash address to classify |
| bank_hit | output | 1 | Address lies in the governed bank |
| mode_o | output | 6 | Current mode bits to the flash controller |
| protect_o | output | 1 | Error protection state active |

## Verification
The bench writes mode values with two bits set, including erase setup together with program setup, and then confirms that the old mode survives. A design that accepted such writes, or that merged them bitwise, would leave an illegal combination on `mode_o`.

It drops each enable while a mode is held. A design that only gated new writes would keep the stale mode active.

It raises `err_in` once during a verify mode and once during erase. A design that latched errors unconditionally would enter protection too early. A design whose protection was not sticky would accept the write that follows.

It probes the bank comparator one address below, at and above each bank edge to catch off-by-one bounds.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    localparam int REG_W  = 8;
    localparam int MODE_W = 6;

    typedef struct packed {
        logic esu;   // erase setup
        logic psu;   // program setup
        logic ev;    // erase verify
        logic pv;    // program verify
        logic ers;   // erase
        logic prg;   // program
    } mode_t;

    function automatic logic mode_legal(input mode_t m);
        return $countones(m) <= 1;
    endfunction

    function automatic logic op_active(input mode_t m);
        return m.ers | m.prg;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input logic err, input mode_t m);
        return {err, 1'b0, m};
    endfunction

endpackage

// File: rtl/flash_pe_errlatch.sv
module flash_pe_errlatch
    import flash_pe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  err_in,
    input  mode_t mode_q,
    output logic  set_now,
    output logic  err_q
);
    assign set_now = err_in & op_active(mode_q) & ~err_q;

    always_ff @(posedge clk) begin
        if (rst)          err_q <= 1'b0;
        else if (set_now) err_q <= 1'b1;
    end
endmodule

// File: rtl/flash_pe_modereg.sv
module flash_pe_modereg
    import flash_pe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  mode_t wr_mode,
    input  logic  fwe,
    input  logic  swe,
    input  logic  kill,
    output mode_t mode_q
);
    mode_t mode_d;
    logic  enabled;

    assign enabled = fwe & swe;

    always_comb begin
        mode_d = mode_q;
        if (kill || !enabled)                   mode_d = '0;
        else if (wr_en && mode_legal(wr_mode))  mode_d = wr_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= mode_d;
    end
endmodule

// File: rtl/flash_pe_bankdec.sv
module flash_pe_bankdec #(
    parameter int          FADDR_W   = 20,
    parameter logic [31:0] BANK_BASE = 32'h2_0000,
    parameter logic [31:0] BANK_LAST = 32'h3_FFFF
) (
    input  logic [FADDR_W-1:0] addr,
    output logic               hit
);
    localparam logic [FADDR_W-1:0] LO = BANK_BASE[FADDR_W-1:0];
    localparam logic [FADDR_W-1:0] HI = BANK_LAST[FADDR_W-1:0];

    assign hit = (addr >= LO) && (addr <= HI);
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
    import flash_pe_pkg::*;
#(
    parameter int          FADDR_W   = 20,
    parameter logic [31:0] BANK_BASE = 32'h2_0000,
    parameter logic [31:0] BANK_LAST = 32'h3_FFFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               fwe_pin,
    input  logic               swe_en,
    input  logic               err_in,
    input  logic [FADDR_W-1:0] flash_addr,
    output logic               bank_hit,
    output logic [MODE_W-1:0]  mode_o,
    output logic               protect_o
);
    mode_t mode_q;
    logic  err_q;
    logic  set_now;

    flash_pe_errlatch i_err (
        .clk     (clk),
        .rst     (rst),
        .err_in  (err_in),
        .mode_q  (mode_q),
        .set_now (set_now),
        .err_q   (err_q)
    );

    flash_pe_modereg i_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .wr_mode (mode_t'(reg_wdata[MODE_W-1:0])),
        .fwe     (fwe_pin),
        .swe     (swe_en),
        .kill    (err_q | set_now),
        .mode_q  (mode_q)
    );

    flash_pe_bankdec #(
        .FADDR_W   (FADDR_W),
        .BANK_BASE (BANK_BASE),
        .BANK_LAST (BANK_LAST)
    ) i_bank (
        .addr (flash_addr),
        .hit  (bank_hit)
    );

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= pack_status(err_q, mode_q);
    end

    assign mode_o    = mode_q;
    assign protect_o = err_q;
endmodule

// File: rtl/flash_pe_ctrl_chk.sv
module flash_pe_ctrl_chk
    import flash_pe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fwe_pin,
    input logic              swe_en,
    input logic              err_in,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [MODE_W-1:0] mode_o,
    input logic              protect_o
);
    // R4
    mode_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mode_o));

    // R6
    enable_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !(fwe_pin && swe_en) |=> mode_o == '0);

    // R7
    err_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (err_in && (mode_o[1] || mode_o[0])) |=> protect_o);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        protect_o |=> protect_o);

    // R9
    protect_clear_chk: assert property (@(posedge clk) disable iff (rst)
        protect_o |-> mode_o == '0);

    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[6] == 1'b0);
endmodule

bind flash_pe_ctrl flash_pe_ctrl_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .fwe_pin   (fwe_pin),
    .swe_en    (swe_en),
    .err_in    (err_in),
    .reg_rdata (reg_rdata),
    .mode_o    (mode_o),
    .protect_o (protect_o)
);

// File: tb/test_flash_pe_ctrl.sv
module test_flash_pe_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        fwe_pin = 1'b0, swe_en = 1'b0, err_in = 1'b0;
    logic [19:0] flash_addr = '0;
    logic        bank_hit;
    logic [5:0]  mode_o;
    logic        protect_o;

    int checks = 0, fails = 0;
    logic [5:0] m_mode = '0;
    logic       m_err  = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #5 clk = ~clk;

    flash_pe_ctrl i_flash_pe_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fwe_pin(fwe_pin), .swe_en(swe_en), .err_in(err_in),
        .flash_addr(flash_addr), .bank_hit(bank_hit),
        .mode_o(mode_o), .protect_o(protect_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares read data one cycle after the read strobe
    always @(posedge clk) rd_seen <= reg_rd;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string      t = tag_q.pop_front();
            check(t, reg_rdata, e);
        end
    end

    // driver: one clock per call, starting and ending at a falling edge
    task automatic step(input logic wr, input logic rd, input logic [7:0] wd,
                        input logic fwe, input logic swe, input logic errp,
                        input string tag);
        logic set;
        reg_wr = wr; reg_rd = rd; reg_wdata = wd;
        fwe_pin = fwe; swe_en = swe; err_in = errp;
        if (rd) begin
            exp_q.push_back({m_err, 1'b0, m_mode});
            tag_q.push_back(tag);
        end
        set = errp && (m_mode[1] || m_mode[0]) && !m_err;
        if (m_err || set)                               m_mode = '0;
        else if (!(fwe && swe))                         m_mode = '0;
        else if (wr && ($countones(wd[5:0]) <= 1))      m_mode = wd[5:0];
        if (set) m_err = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; err_in = 1'b0;
        check({tag, " mode"}, mode_o, m_mode);
        check({tag, " protect"}, protect_o, m_err);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        m_mode = '0; m_err = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 mode", mode_o, 0);
        check("R1 protect", protect_o, 0);
        step(0, 1, 8'h00, 0, 0, 0, "R1 read");
        step(0, 0, 8'h00, 0, 0, 0, "R1 idle");

        step(1, 0, 8'h20, 1, 1, 0, "R3 erase setup");
        step(0, 1, 8'h00, 1, 1, 0, "R2 read esu");
        step(0, 0, 8'h00, 1, 1, 0, "R2 idle");
        step(1, 0, 8'h01, 1, 1, 0, "R3 program");
        step(1, 0, 8'h03, 1, 1, 0, "R4 two ops");
        step(1, 0, 8'h30, 1, 1, 0, "R4 both setups");
        step(1, 0, 8'h0C, 1, 1, 0, "R4 both verifies");
        step(1, 0, 8'hC2, 1, 1, 0, "R5 upper bits");
        step(0, 1, 8'h00, 1, 1, 0, "R5 read back");
        step(0, 0, 8'h00, 1, 1, 0, "R5 idle");
        step(1, 0, 8'h00, 1, 1, 0, "R3 clear");

        step(1, 0, 8'h10, 0, 1, 0, "R6 fwe low write");
        step(1, 0, 8'h20, 1, 0, 0, "R6 swe low write");
        step(1, 0, 8'h04, 1, 1, 0, "R3 program verify");
        step(0, 0, 8'h00, 1, 0, 0, "R6 swe drop");
        step(1, 0, 8'h08, 1, 1, 0, "R3 erase verify");
        step(0, 0, 8'h00, 0, 1, 0, "R6 fwe drop");

        step(1, 0, 8'h08, 1, 1, 0, "R3 ev again");
        step(0, 0, 8'h00, 1, 1, 1, "R8 err in verify");
        step(1, 0, 8'h02, 1, 1, 0, "R3 erase");
        step(0, 0, 8'h00, 1, 1, 1, "R7 err in erase");
        step(0, 1, 8'h00, 1, 1, 0, "R7 read err");
        step(1, 0, 8'h01, 1, 1, 0, "R9 write blocked");
        step(1, 0, 8'h20, 1, 1, 0, "R9 setup blocked");
        step(1, 0, 8'h00, 1, 1, 0, "R9 zero write keeps flag");
        do_reset();
        check("R9 reset clears flag", protect_o, 0);
        step(1, 0, 8'h10, 1, 1, 0, "R3 after reset");

        flash_addr = 20'h1FFFF; #1 check("R10 below", bank_hit, 0);
        flash_addr = 20'h20000; #1 check("R10 base", bank_hit, 1);
        flash_addr = 20'h3FFFF; #1 check("R10 last", bank_hit, 1);
        flash_addr = 20'h40000; #1 check("R10 above", bank_hit, 0);
        flash_addr = 20'h00000; #1 check("R10 zero", bank_hit, 0);

        @(negedge clk); @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule